// File: doc/BRIEF.md
# Linear CCD Drive Clock Sequencer

This block derives all drive waveforms of a three-row colour linear CCD from a single fast system clock. During each pixel period it produces a complementary two-phase shift clock and a last-stage shift clock that follows phase one. It also produces a reset-gate pulse placed at a programmed offset inside the pixel, and a clamp pulse. One transfer-gate pulse serves all three colour rows. Between lines the shift clocks are frozen for a programmable guard interval before and after that pulse.

Every width and spacing is given as a count of system-clock ticks: the pixel period, the reset offset and width, the clamp width, the guard interval and the transfer width. The line length is given as three counts: dark (shielded) pixels, valid pixels and trailing dummy pixels. The clamp runs either once per pixel or once per line. A single-cycle line-start strobe and three pixel-class flags frame the samples for an external converter. A configuration the sensor cannot follow is flagged, and while it is flagged the sequencer parks in a frozen state.

Top module: `ccd_clkgen`

## Requirements
- R1: During the shift phase of a line, pixel index p (counted from 0) raises exactly one flag: pixDark for p < cfgDarkPix, pixValid for the next cfgValidPix pixels, and pixTail for the next cfgTailPix pixels. No flag is raised outside the shift phase.
- R2: lineStart is high for exactly one clock, during tick 0 of pixel 0 of each line, and the next one follows N*P + 2*H + G clocks later. Here N is the sum of the three pixel counts, P is cfgPixTicks, H is cfgGapTicks and G is cfgTgTicks.
- R3: Within each pixel (ticks 0..P-1), phi1 and phi1Last are high for ticks t < floor(P/2) and low for the rest of the pixel; phi2 is always the complement of phi1.
- R4: In the shift phase, rstGate is high exactly for ticks D <= t < D+W of each pixel, where D is cfgRgDelay and W is cfgRgWidth.
- R5: After the last pixel, phi1 is held high and phi2 low for H clocks, then tgOut is high for G clocks, then phi1 stays high and phi2 low for H more clocks before the next line starts.
- R6: rstGate is high for every clock in which tgOut is high, and low during both guard intervals.
- R7: With cfgLineClamp = 0, clampOut is high exactly for ticks D+W <= t < D+W+C of each pixel, where C is cfgClWidth, and low outside the shift phase. It never overlaps the reset pulse.
- R8: With cfgLineClamp = 1, clampOut is low across the guard, transfer and guard intervals and high throughout the shift phase. Reset pulses occur only while clampOut is high, except during the forced-high transfer interval.
- R9: cfgErr is high exactly when any of these holds: P < MIN_PIX_TICKS (default 5, which is 100 ns at 50 MHz), D+W+C > P, any of W, C, H or G is zero, or N is zero. A configuration with D+W+C = P is accepted. While cfgErr is held, the sequencer stays frozen with phi1 high and produces no tgOut and no lineStart.
- R10: During reset, phi1 and phi1Last are high and all other outputs are low. After reset release, the first lineStart is seen 2*H + G + 1 clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPixTicks | input | 8 | Pixel period in ticks |
| cfgRgDelay | input | 8 | Tick offset of the reset pulse from the phi1 rising edge |
| cfgRgWidth | input | 8 | Reset pulse width in ticks |
| cfgClWidth | input | 8 | Per-pixel clamp width in ticks |
| cfgGapTicks | input | 12 | Frozen guard interval before and after the transfer pulse |
| cfgTgTicks | input | 12 | Transfer pulse width in ticks |
| cfgDarkPix | input | 14 | Number of shielded pixels at the head of the line |
| cfgValidPix | input | 14 | Number of valid pixels |
| cfgTailPix | input | 14 | Number of trailing dummy pixels |
| cfgLineClamp | input | 1 | 1 = clamp once per line, 0 = clamp every pixel |
| phi1 | output | 1 | Shift clock phase one |
| phi2 | output | 1 | Shift clock phase two |
| phi1Last | output | 1 | Last-stage shift clock |
| rstGate | output | 1 | Reset-gate pulse |
| clampOut | output | 1 | Clamp pulse |
| tgOut | output | 1 | Transfer-gate pulse shared by the three rows |
| lineStart | output | 1 | One-clock strobe on the first dark pixel |
| pixDark | output | 1 | Current pixel is shielded |
| pixValid | output | 1 | Current pixel is valid |
| pixTail | output | 1 | Current pixel is a trailing dummy |
| cfgErr | output | 1 | Configuration rejected |

## Verification
The properties assume that the configuration inputs, in particular the clamp mode and the dark-pixel count, do not change while a line is running. The registered outputs lag the inputs by one clock, so a change in mid-line could briefly pair a new mode with an old waveform. The stimulus therefore writes every configuration only while reset is held. It then sweeps pixel periods from the minimum upward in both clamp modes, with the clamp window ending on the last tick of the pixel. The rejected configurations are applied the same way and are removed again only under reset.

// File: rtl/ccdclk_pkg.sv
package ccdclk_pkg;
  localparam int TICK_W = 8;
  localparam int GAP_W  = 12;
  localparam int PIX_W  = 14;
  localparam int CNT_W  = PIX_W + 2;

  typedef enum logic [1:0] {SEQ_SETUP, SEQ_TG, SEQ_HOLD, SEQ_SHIFT} seq_e;
  typedef enum logic [1:0] {PC_NONE, PC_DARK, PC_VALID, PC_TAIL} pix_e;

  typedef struct packed {
    logic              inShift;
    logic              inTg;
    logic              lineHead;
    pix_e              pixClass;
    logic [TICK_W-1:0] tick;
  } seq_strobe_t;
endpackage

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              idle,
  input  logic [TICK_W-1:0] pixTicks,
  input  logic [GAP_W-1:0]  gapTicks,
  input  logic [GAP_W-1:0]  tgTicks,
  input  logic [CNT_W-1:0]  darkEnd,
  input  logic [CNT_W-1:0]  validEnd,
  input  logic [CNT_W-1:0]  lastPix,
  output seq_strobe_t       strobe
);
  seq_e              state;
  logic [GAP_W-1:0]  gapCnt;
  logic [TICK_W-1:0] tick;
  logic [CNT_W-1:0]  pix;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= SEQ_SETUP;
      gapCnt <= '0;
      tick   <= '0;
      pix    <= '0;
    end else if (idle) begin
      state  <= SEQ_SETUP;
      gapCnt <= '0;
      tick   <= '0;
      pix    <= '0;
    end else begin
      unique case (state)
        SEQ_SETUP: begin
          if (gapCnt == gapTicks - 1'b1) begin
            state  <= SEQ_TG;
            gapCnt <= '0;
          end else gapCnt <= gapCnt + 1'b1;
        end
        SEQ_TG: begin
          if (gapCnt == tgTicks - 1'b1) begin
            state  <= SEQ_HOLD;
            gapCnt <= '0;
          end else gapCnt <= gapCnt + 1'b1;
        end
        SEQ_HOLD: begin
          if (gapCnt == gapTicks - 1'b1) begin
            state  <= SEQ_SHIFT;
            gapCnt <= '0;
            tick   <= '0;
            pix    <= '0;
          end else gapCnt <= gapCnt + 1'b1;
        end
        SEQ_SHIFT: begin
          if (tick == pixTicks - 1'b1) begin
            tick <= '0;
            if (pix == lastPix) begin
              state <= SEQ_SETUP;
              pix   <= '0;
            end else pix <= pix + 1'b1;
          end else tick <= tick + 1'b1;
        end
        default: state <= SEQ_SETUP;
      endcase
    end
  end

  always_comb begin
    strobe.inShift  = (state == SEQ_SHIFT);
    strobe.inTg     = (state == SEQ_TG);
    strobe.lineHead = strobe.inShift && (tick == '0) && (pix == '0);
    strobe.tick     = tick;
    if (!strobe.inShift)      strobe.pixClass = PC_NONE;
    else if (pix < darkEnd)   strobe.pixClass = PC_DARK;
    else if (pix < validEnd)  strobe.pixClass = PC_VALID;
    else                      strobe.pixClass = PC_TAIL;
  end
endmodule

// File: rtl/ccd_wave_gen.sv
module ccd_wave_gen
  import ccdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [TICK_W-1:0] pixTicks,
  input  logic [TICK_W-1:0] rgDelay,
  input  logic [TICK_W-1:0] rgWidth,
  input  logic [TICK_W-1:0] clWidth,
  input  logic              lineClamp,
  output logic              phi1,
  output logic              phi2,
  output logic              phi1Last,
  output logic              rstGate,
  output logic              clampOut,
  output logic              tgOut,
  output logic              lineStart,
  output logic              pixDark,
  output logic              pixValid,
  output logic              pixTail
);
  localparam int XW = TICK_W + 2;

  logic [XW-1:0] tickX, rgStart, rgEnd, clEnd, halfX;
  logic firstHalf, rgWin, clWin, shiftHigh;

  always_comb begin
    tickX     = {2'b00, strobe.tick};
    rgStart   = {2'b00, rgDelay};
    rgEnd     = rgStart + {2'b00, rgWidth};
    clEnd     = rgEnd + {2'b00, clWidth};
    halfX     = {2'b00, pixTicks} >> 1;
    firstHalf = tickX < halfX;
    rgWin     = (tickX >= rgStart) && (tickX < rgEnd);
    clWin     = (tickX >= rgEnd) && (tickX < clEnd);
    shiftHigh = !strobe.inShift || firstHalf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phi1      <= 1'b1;
      phi2      <= 1'b0;
      phi1Last  <= 1'b1;
      rstGate   <= 1'b0;
      clampOut  <= 1'b0;
      tgOut     <= 1'b0;
      lineStart <= 1'b0;
      pixDark   <= 1'b0;
      pixValid  <= 1'b0;
      pixTail   <= 1'b0;
    end else begin
      phi1      <= shiftHigh;
      phi2      <= !shiftHigh;
      phi1Last  <= shiftHigh;
      rstGate   <= strobe.inTg || (strobe.inShift && rgWin);
      clampOut  <= strobe.inShift && (lineClamp || clWin);
      tgOut     <= strobe.inTg;
      lineStart <= strobe.lineHead;
      pixDark   <= (strobe.pixClass == PC_DARK);
      pixValid  <= (strobe.pixClass == PC_VALID);
      pixTail   <= (strobe.pixClass == PC_TAIL);
    end
  end
endmodule

// File: rtl/ccd_clkgen.sv
module ccd_clkgen
  import ccdclk_pkg::*;
#(
  parameter int MIN_PIX_TICKS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TICK_W-1:0] cfgPixTicks,
  input  logic [TICK_W-1:0] cfgRgDelay,
  input  logic [TICK_W-1:0] cfgRgWidth,
  input  logic [TICK_W-1:0] cfgClWidth,
  input  logic [GAP_W-1:0]  cfgGapTicks,
  input  logic [GAP_W-1:0]  cfgTgTicks,
  input  logic [PIX_W-1:0]  cfgDarkPix,
  input  logic [PIX_W-1:0]  cfgValidPix,
  input  logic [PIX_W-1:0]  cfgTailPix,
  input  logic              cfgLineClamp,
  output logic              phi1,
  output logic              phi2,
  output logic              phi1Last,
  output logic              rstGate,
  output logic              clampOut,
  output logic              tgOut,
  output logic              lineStart,
  output logic              pixDark,
  output logic              pixValid,
  output logic              pixTail,
  output logic              cfgErr
);
  localparam int SW = TICK_W + 2;

  logic [CNT_W-1:0] darkEnd, validEnd, totalPix, lastPix;
  logic [SW-1:0]    pulseSum;
  seq_strobe_t      strobe;

  always_comb begin
    darkEnd  = {2'b00, cfgDarkPix};
    validEnd = darkEnd + {2'b00, cfgValidPix};
    totalPix = validEnd + {2'b00, cfgTailPix};
    lastPix  = totalPix - 1'b1;
    pulseSum = {2'b00, cfgRgDelay} + {2'b00, cfgRgWidth} + {2'b00, cfgClWidth};
    cfgErr   = (cfgPixTicks < TICK_W'(MIN_PIX_TICKS))
            || (pulseSum > {2'b00, cfgPixTicks})
            || (cfgRgWidth == '0) || (cfgClWidth == '0)
            || (cfgGapTicks == '0) || (cfgTgTicks == '0)
            || (totalPix == '0);
  end

  ccd_line_seq u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .idle     (cfgErr),
    .pixTicks (cfgPixTicks),
    .gapTicks (cfgGapTicks),
    .tgTicks  (cfgTgTicks),
    .darkEnd  (darkEnd),
    .validEnd (validEnd),
    .lastPix  (lastPix),
    .strobe   (strobe)
  );

  ccd_wave_gen u_wave (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pixTicks  (cfgPixTicks),
    .rgDelay   (cfgRgDelay),
    .rgWidth   (cfgRgWidth),
    .clWidth   (cfgClWidth),
    .lineClamp (cfgLineClamp),
    .phi1      (phi1),
    .phi2      (phi2),
    .phi1Last  (phi1Last),
    .rstGate   (rstGate),
    .clampOut  (clampOut),
    .tgOut     (tgOut),
    .lineStart (lineStart),
    .pixDark   (pixDark),
    .pixValid  (pixValid),
    .pixTail   (pixTail)
  );
endmodule

// File: rtl/ccd_clkgen_chk.sv
module ccd_clkgen_chk
  import ccdclk_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cfgLineClamp,
  input logic [PIX_W-1:0] cfgDarkPix,
  input logic             phi1,
  input logic             phi2,
  input logic             rstGate,
  input logic             clampOut,
  input logic             tgOut,
  input logic             lineStart,
  input logic             pixDark,
  input logic             pixValid,
  input logic             pixTail,
  input logic             cfgErr
);
  a_r6_rg_high_in_tg: assert property (@(posedge clk) disable iff (!rstN)
    tgOut |-> rstGate);

  a_r5_frozen_in_tg: assert property (@(posedge clk) disable iff (!rstN)
    tgOut |-> (phi1 && !phi2 && $stable(phi1)));

  a_r5_guard_before_tg: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgOut) |-> ($past(phi1) && !$past(phi2) && !$past(rstGate)));

  a_r8_no_rg_while_clamp_low: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLineClamp && !clampOut && !tgOut) |-> !rstGate);

  a_r7_clamp_apart_from_rg: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLineClamp && clampOut) |-> !rstGate);

  a_r1_flags_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pixDark, pixValid, pixTail}));

  a_r1_no_flag_in_tg: assert property (@(posedge clk) disable iff (!rstN)
    tgOut |-> !(pixDark || pixValid || pixTail));

  a_r2_start_on_dark: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && (cfgDarkPix != '0)) |-> pixDark);

  a_r9_parked_on_error: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && $past(cfgErr)) |=> (!tgOut && !lineStart));
endmodule

bind ccd_clkgen ccd_clkgen_chk u_chk (.*);

// File: tb/tb_ccd_clkgen.sv
`timescale 1ns/1ps
module tb_ccd_clkgen;
  import ccdclk_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [TICK_W-1:0] cfgPixTicks = 8'd6, cfgRgDelay = 8'd1, cfgRgWidth = 8'd1, cfgClWidth = 8'd1;
  logic [GAP_W-1:0]  cfgGapTicks = 12'd2, cfgTgTicks = 12'd4;
  logic [PIX_W-1:0]  cfgDarkPix = 14'd2, cfgValidPix = 14'd3, cfgTailPix = 14'd1;
  logic cfgLineClamp = 1'b0;
  logic phi1, phi2, phi1Last, rstGate, clampOut, tgOut, lineStart;
  logic pixDark, pixValid, pixTail, cfgErr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ccd_clkgen dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setCfg(input int p, input int d, input int w, input int c,
                        input int h, input int g, input int dk, input int vl,
                        input int tl, input int mode);
    rstN = 1'b0;
    @(negedge clk);
    cfgPixTicks = TICK_W'(p); cfgRgDelay = TICK_W'(d);
    cfgRgWidth = TICK_W'(w); cfgClWidth = TICK_W'(c);
    cfgGapTicks = GAP_W'(h); cfgTgTicks = GAP_W'(g);
    cfgDarkPix = PIX_W'(dk); cfgValidPix = PIX_W'(vl); cfgTailPix = PIX_W'(tl);
    cfgLineClamp = mode[0];
    @(negedge clk);
    @(negedge clk);
  endtask

  // Runs one accepted configuration: reset state, start latency, two full lines.
  task automatic runCfg(input int p, input int d, input int w, input int c,
                        input int h, input int g, input int dk, input int vl,
                        input int tl, input int mode);
    int n, per, cnt;
    setCfg(p, d, w, c, h, g, dk, vl, tl, mode);
    // R10: reset state
    chk("R10 phi1 in reset", phi1, 1);
    chk("R10 phi1Last in reset", phi1Last, 1);
    chk("R10 others low in reset",
        {phi2, rstGate, clampOut, tgOut, lineStart, pixDark, pixValid, pixTail}, 0);
    chk("R9 accepted config", cfgErr, 0);
    rstN = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!lineStart && cnt < 5000);
    chk("R10 first lineStart latency", cnt, 2*h + g + 1);
    n = dk + vl + tl;
    per = n*p + 2*h + g;
    for (int ln = 0; ln < 2; ln++) begin
      for (int j = 0; j < per; j++) begin
        int eP1, eRg, eCl, eTg, eDk, eVl, eTl, eLs;
        if (j < n*p) begin
          int px = j / p;
          int t  = j % p;
          eP1 = (t < p/2) ? 1 : 0;
          eRg = (t >= d && t < d+w) ? 1 : 0;
          eCl = (mode != 0) ? 1 : ((t >= d+w && t < d+w+c) ? 1 : 0);
          eTg = 0;
          eDk = (px < dk) ? 1 : 0;
          eVl = (px >= dk && px < dk+vl) ? 1 : 0;
          eTl = (px >= dk+vl) ? 1 : 0;
          eLs = (j == 0) ? 1 : 0;
          chk("R3 phi1", phi1, eP1);
          chk("R3 phi1Last", phi1Last, eP1);
          chk("R3 phi2", phi2, 1 - eP1);
          chk("R4 rstGate", rstGate, eRg);
          if (mode != 0) chk("R8 clamp line mode", clampOut, eCl);
          else           chk("R7 clamp pixel mode", clampOut, eCl);
          chk("R1 flags", {pixDark, pixValid, pixTail}, eDk*4 + eVl*2 + eTl);
          chk("R2 lineStart", lineStart, eLs);
          chk("R5 tg low in shift", tgOut, eTg);
        end else begin
          int gp = j - n*p;
          eTg = (gp >= h && gp < h+g) ? 1 : 0;
          chk("R5 phi1 frozen high", phi1, 1);
          chk("R5 phi2 frozen low", phi2, 0);
          chk("R5 tgOut", tgOut, eTg);
          chk("R6 rstGate", rstGate, eTg);
          if (mode != 0) chk("R8 clamp low around tg", clampOut, 0);
          else           chk("R7 clamp low outside shift", clampOut, 0);
          chk("R1 no flags", {pixDark, pixValid, pixTail}, 0);
          chk("R2 lineStart low", lineStart, 0);
        end
        @(negedge clk);
      end
    end
    chk("R2 next line start", lineStart, 1);
  endtask

  task automatic runBad(input string why, input int p, input int d, input int w,
                        input int c, input int h, input int g, input int dk,
                        input int vl, input int tl);
    int seenTg, seenLs, lowPhi;
    setCfg(p, d, w, c, h, g, dk, vl, tl, 0);
    chk(why, cfgErr, 1);
    rstN = 1'b1;
    seenTg = 0; seenLs = 0; lowPhi = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      seenTg += tgOut;
      seenLs += lineStart;
      lowPhi += (phi1 == 1'b0) ? 1 : 0;
    end
    chk("R9 no tg while rejected", seenTg, 0);
    chk("R9 no lineStart while rejected", seenLs, 0);
    chk("R9 phi1 parked high", lowPhi, 0);
  endtask

  initial begin
    #(20ns * 200000);
    failures++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Sweep pixel periods from the minimum, both clamp modes; clamp ends on last tick.
    for (int p = 5; p <= 8; p++) begin
      for (int m = 0; m < 2; m++) begin
        int w = 1 + (p % 2);
        runCfg(p, 1, w, p - 1 - w, 1 + (p % 3), 2 + p, 2, 3, 1 + m, m);
      end
    end
    // Shifted reset pulse, no dark pixels, longer guard
    runCfg(9, 3, 2, 2, 4, 6, 0, 4, 2, 0);
    // Rejected configurations
    runBad("R9 period below minimum", 4, 1, 1, 1, 2, 3, 2, 2, 1);
    runBad("R9 pulses overrun period", 6, 2, 2, 3, 2, 3, 2, 2, 1);
    runBad("R9 zero transfer width", 6, 1, 1, 1, 2, 0, 2, 2, 1);
    runBad("R9 empty line", 6, 1, 1, 1, 2, 3, 0, 0, 0);
    // Recovery after error under reset
    runCfg(6, 1, 1, 2, 2, 3, 1, 2, 1, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule